// File: doc/BRIEF.md
# SPI Slave Shift Engine with Ready/Wait Handshake

This block is the receive-and-transmit core of an SPI slave. It shifts one character per chip-select window, most significant bit first, in both directions at once. The character length can be set from 2 to 16 bits. The serial clock, chip select and data-in pins are brought into the system clock domain through two-flop synchronizers, and all edge detection runs on the synchronized copies. For this reason the system clock must run at least four times faster than the serial clock. The serial timing is mode 0: data-in is sampled on the rising serial-clock edge, and data-out moves on the falling edge.

The slave paces the master with an active-low ready line. Once software has written the next transmit word, the line is pulled low, which tells the master it may clock. When a character completes, the line goes back to "not ready". A configuration bit selects how that happens: the line is either driven high or released to high impedance, so that several slaves can share one pulled-up line.

Chip select can be released in the middle of a character. When that happens, the slave floats its data-out line, and it also floats the ready line when the high-impedance option is selected. If serial-clock edges then arrive while the slave is deselected, the slave abandons the character and sets a sticky length-error flag. That flag can raise an interrupt.

Top module: `spi_wait_slave`

## Requirements
- R1: The effective character length is `cfgLen` clamped to 2..16. `misoOut` presents transmit bit (length-1) first, then each lower bit in turn. It advances on each falling serial-clock edge while chip select is low.
- R2: On the rising serial-clock edge that completes a character, `rxData` takes the received bits. The first received bit lands at bit (length-1), and the bits above the length read zero. `rxFull` is set at the same time and is cleared by a one-cycle `rxRead` pulse.
- R3: A `txWrite` pulse loads `txData` into the transmit shift register when the bit counter is zero. With the ready function on, the ready line is then driven low (`rdyOe`=1, `rdyOut`=0). A `txWrite` pulse in the middle of a character is ignored.
- R4: While no transmit word is pending, with `cfgHighZ`=0, the ready line is driven high (`rdyOe`=1, `rdyOut`=1). This applies after reset and after each completed character.
- R5: With `cfgHighZ`=1, completing a character releases the ready line (`rdyOe`=0), and the line is never driven high.
- R6: With `cfgRdyEn`=0, `rdyOe` stays 0, and characters are still shifted and received normally.
- R7: `misoOe` is 1 only while chip select is asserted (low).
- R8: Raising chip select with the bit counter non-zero floats `misoOut` (`misoOe`=0). The ready line is then released when `cfgHighZ`=1, or driven high when `cfgHighZ`=0. No error is flagged at this point.
- R9: After such an early release, a serial-clock edge seen while chip select stays high sets `errFlag`. The flag stays set until an `errClr` pulse. `irqOut` equals `errFlag` AND `irqEn`. Clock edges while deselected after a completed character set no error.
- R10: Asserting chip select again clears the bit counter. After an early release, the next full character is received and transmitted correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgLen | input | 5 | Character length in bits, clamped to 2..16 |
| cfgRdyEn | input | 1 | Enables the ready/wait line |
| cfgHighZ | input | 1 | 1: ready line released when not ready; 0: driven high |
| irqEn | input | 1 | Interrupt enable for the length error |
| txData | input | 16 | Next transmit word |
| txWrite | input | 1 | One-cycle strobe that loads `txData` |
| rxData | output | 16 | Last received character, right-aligned |
| rxFull | output | 1 | A received character is waiting |
| rxRead | input | 1 | One-cycle strobe that clears `rxFull` |
| errFlag | output | 1 | Sticky data-length error |
| errClr | input | 1 | One-cycle strobe that clears `errFlag` |
| irqOut | output | 1 | Error interrupt request |
| sclkIn | input | 1 | Serial clock from the master |
| csN | input | 1 | Chip select, active low |
| mosiIn | input | 1 | Serial data from the master |
| misoOut | output | 1 | Serial data to the master |
| misoOe | output | 1 | Output enable for `misoOut` |
| rdyOut | output | 1 | Ready line value, low means ready |
| rdyOe | output | 1 | Output enable for the ready line |

## Verification
The hardest situation to reach is the length error. It needs a character stopped partway, chip select released while the bit counter is non-zero, and then a clock edge while deselected. The bench drives the serial side with a task that can shift any slice of a character. It uses that task to stop after a few bits, raise chip select, and toggle the clock once, checking the line states and the flag between each step. It then reasserts chip select and runs a full character, to show that the counter starts over.

// File: rtl/spi_wait_pkg.sv
package spi_wait_pkg;

  // Strobes from the control block to the datapath, one cycle each.
  typedef struct packed {
    logic loadTx;     // copy txData into the transmit shifter
    logic shiftTx;    // advance the transmit shifter by one bit
    logic shiftRx;    // take one sampled data-in bit
    logic capture;    // last bit of a character: publish rxData
    logic clearCnt;   // restart the bit counter
    logic clearFull;  // consumer has read rxData
  } dpCtl_t;

endpackage

// File: rtl/spi_wait_sync.sv
module spi_wait_sync #(
  parameter int WIDTH = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  for (genvar g = 0; g < WIDTH; g++) begin : gSync
    logic [1:0] stage;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage <= {2{RST_VAL[g]}};
      else       stage <= {stage[0], asyncIn[g]};
    end
    assign syncOut[g] = stage[1];
  end

endmodule

// File: rtl/spi_wait_ctrl.sv
module spi_wait_ctrl
  import spi_wait_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   sclkS,
  input  logic   csNS,
  input  logic   cfgRdyEn,
  input  logic   cfgHighZ,
  input  logic   irqEn,
  input  logic   txWrite,
  input  logic   rxRead,
  input  logic   errClr,
  input  logic   midChar,
  input  logic   lastBit,
  output dpCtl_t dpCtl,
  output logic   misoOe,
  output logic   rdyOut,
  output logic   rdyOe,
  output logic   errFlag,
  output logic   irqOut
);

  logic sclkQ, csNQ;
  logic csLost, txLoaded;
  logic sclkRise, sclkFall, csAssert, csRelease, active;
  logic errEvent, accept;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ <= 1'b0;
      csNQ  <= 1'b1;
    end else begin
      sclkQ <= sclkS;
      csNQ  <= csNS;
    end
  end

  assign sclkRise  = sclkS & ~sclkQ;
  assign sclkFall  = ~sclkS & sclkQ;
  assign csAssert  = ~csNS & csNQ;
  assign csRelease = csNS & ~csNQ;
  assign active    = ~csNS;
  assign errEvent  = csLost & csNS & (sclkRise | sclkFall);
  assign accept    = txWrite & ~midChar;

  always_comb begin
    dpCtl           = '0;
    dpCtl.loadTx    = accept;
    dpCtl.shiftRx   = active & sclkRise;
    dpCtl.capture   = active & sclkRise & lastBit;
    dpCtl.shiftTx   = active & sclkFall;
    dpCtl.clearCnt  = csAssert | errEvent;
    dpCtl.clearFull = rxRead;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csLost   <= 1'b0;
      txLoaded <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      if (csAssert)                  csLost <= 1'b0;
      else if (errEvent)             csLost <= 1'b0;
      else if (csRelease && midChar) csLost <= 1'b1;

      if (dpCtl.capture) txLoaded <= 1'b0;
      else if (accept)   txLoaded <= 1'b1;

      if (errEvent)    errFlag <= 1'b1;
      else if (errClr) errFlag <= 1'b0;
    end
  end

  // Ready line: low = go, high or released = wait.
  always_comb begin
    if (!cfgRdyEn) begin
      rdyOe  = 1'b0;
      rdyOut = 1'b1;
    end else if (txLoaded && !csLost) begin
      rdyOe  = 1'b1;
      rdyOut = 1'b0;
    end else if (cfgHighZ) begin
      rdyOe  = 1'b0;
      rdyOut = 1'b1;
    end else begin
      rdyOe  = 1'b1;
      rdyOut = 1'b1;
    end
  end

  assign misoOe = active;
  assign irqOut = errFlag & irqEn;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errFlag && !errClr |=> errFlag); // R9
  AST_LOST_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csLost) |-> csNS); // R8
  AST_HZ_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdyEn && cfgHighZ |-> !(rdyOe && rdyOut)); // R5

endmodule

// File: rtl/spi_wait_dp.sv
module spi_wait_dp
  import spi_wait_pkg::*;
#(
  parameter int MAX_LEN = 16,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtl_t             ctl,
  input  logic [LEN_W-1:0]   cfgLen,
  input  logic [MAX_LEN-1:0] txData,
  input  logic               mosiS,
  output logic               misoOut,
  output logic [MAX_LEN-1:0] rxData,
  output logic               rxFull,
  output logic               midChar,
  output logic               lastBit
);

  localparam int IDX_W = $clog2(MAX_LEN);
  localparam int MIN_LEN = 2;

  logic [LEN_W-1:0]   effLen;
  logic [LEN_W-1:0]   bitCnt;
  logic [IDX_W-1:0]   msbIdx;
  logic [MAX_LEN-1:0] txSh, rxSh, lenMask, rxNext;

  always_comb begin
    if (cfgLen < LEN_W'(MIN_LEN))      effLen = LEN_W'(MIN_LEN);
    else if (cfgLen > LEN_W'(MAX_LEN)) effLen = LEN_W'(MAX_LEN);
    else                               effLen = cfgLen;
  end

  always_comb begin
    for (int i = 0; i < MAX_LEN; i++) lenMask[i] = (i < int'(effLen));
  end

  assign msbIdx  = IDX_W'(effLen - LEN_W'(1));
  assign midChar = (bitCnt != '0);
  assign lastBit = (bitCnt == effLen - LEN_W'(1));
  assign misoOut = txSh[msbIdx];
  assign rxNext  = {rxSh[MAX_LEN-2:0], mosiS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      txSh   <= '0;
      rxSh   <= '0;
      rxData <= '0;
      rxFull <= 1'b0;
    end else begin
      if (ctl.clearCnt || ctl.capture) bitCnt <= '0;
      else if (ctl.shiftRx)            bitCnt <= bitCnt + LEN_W'(1);

      if (ctl.loadTx)       txSh <= txData;
      else if (ctl.shiftTx) txSh <= txSh << 1;

      if (ctl.shiftRx) rxSh <= rxNext;

      if (ctl.capture) rxData <= rxNext & lenMask;

      if (ctl.capture)        rxFull <= 1'b1;
      else if (ctl.clearFull) rxFull <= 1'b0;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt < effLen); // R1
  AST_FULL_AFTER_CAP: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> rxFull); // R2
  AST_LOAD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadTx |-> bitCnt == '0); // R3

endmodule

// File: rtl/spi_wait_slave.sv
module spi_wait_slave
  import spi_wait_pkg::*;
#(
  parameter int MAX_LEN = 16,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LEN_W-1:0]   cfgLen,
  input  logic               cfgRdyEn,
  input  logic               cfgHighZ,
  input  logic               irqEn,
  input  logic [MAX_LEN-1:0] txData,
  input  logic               txWrite,
  output logic [MAX_LEN-1:0] rxData,
  output logic               rxFull,
  input  logic               rxRead,
  output logic               errFlag,
  input  logic               errClr,
  output logic               irqOut,
  input  logic               sclkIn,
  input  logic               csN,
  input  logic               mosiIn,
  output logic               misoOut,
  output logic               misoOe,
  output logic               rdyOut,
  output logic               rdyOe
);

  logic [2:0] pinSync;
  logic       midChar, lastBit;
  dpCtl_t     dpCtl;

  // bit 2: chip select (idles high), bit 1: serial clock, bit 0: data in
  spi_wait_sync #(.WIDTH(3), .RST_VAL(3'b100)) sync_i (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({csN, sclkIn, mosiIn}),
    .syncOut (pinSync)
  );

  spi_wait_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .sclkS    (pinSync[1]),
    .csNS     (pinSync[2]),
    .cfgRdyEn (cfgRdyEn),
    .cfgHighZ (cfgHighZ),
    .irqEn    (irqEn),
    .txWrite  (txWrite),
    .rxRead   (rxRead),
    .errClr   (errClr),
    .midChar  (midChar),
    .lastBit  (lastBit),
    .dpCtl    (dpCtl),
    .misoOe   (misoOe),
    .rdyOut   (rdyOut),
    .rdyOe    (rdyOe),
    .errFlag  (errFlag),
    .irqOut   (irqOut)
  );

  spi_wait_dp #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (dpCtl),
    .cfgLen  (cfgLen),
    .txData  (txData),
    .mosiS   (pinSync[0]),
    .misoOut (misoOut),
    .rxData  (rxData),
    .rxFull  (rxFull),
    .midChar (midChar),
    .lastBit (lastBit)
  );

  AST_NO_RDY_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !cfgRdyEn |-> !rdyOe); // R6

endmodule

// File: tb/spi_wait_slave_tb_top.sv
module spi_wait_slave_tb_top;

  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] cfgLen = 5'd8;
  logic cfgRdyEn = 1'b1, cfgHighZ = 1'b0, irqEn = 1'b1;
  logic [15:0] txData = '0;
  logic txWrite = 1'b0, rxRead = 1'b0, errClr = 1'b0;
  logic sclkIn = 1'b0, csN = 1'b1, mosiIn = 1'b0;
  logic [15:0] rxData;
  logic rxFull, errFlag, irqOut, misoOut, misoOe, rdyOut, rdyOe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spi_wait_slave dut_i (
    .clk(clk), .rstN(rstN), .cfgLen(cfgLen), .cfgRdyEn(cfgRdyEn),
    .cfgHighZ(cfgHighZ), .irqEn(irqEn), .txData(txData), .txWrite(txWrite),
    .rxData(rxData), .rxFull(rxFull), .rxRead(rxRead), .errFlag(errFlag),
    .errClr(errClr), .irqOut(irqOut), .sclkIn(sclkIn), .csN(csN),
    .mosiIn(mosiIn), .misoOut(misoOut), .misoOe(misoOe), .rdyOut(rdyOut),
    .rdyOe(rdyOe)
  );

  typedef struct packed {
    logic [4:0]  len;
    logic [4:0]  nb;
    logic [15:0] tx;
    logic [15:0] mosi;
    logic [15:0] rx;
    logic [15:0] miso;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{5'd8,  5'd8,  16'h00A5, 16'h003C, 16'h003C, 16'h00A5},
    '{5'd16, 5'd16, 16'hBEEF, 16'h1234, 16'h1234, 16'hBEEF},
    '{5'd2,  5'd2,  16'h0002, 16'h0001, 16'h0001, 16'h0002},
    '{5'd5,  5'd5,  16'h0015, 16'h000A, 16'h000A, 16'h0015},
    '{5'd0,  5'd2,  16'hFFFE, 16'h0003, 16'h0003, 16'h0002},
    '{5'd31, 5'd16, 16'h8001, 16'hC003, 16'hC003, 16'h8001},
    '{5'd4,  5'd4,  16'h123C, 16'h000B, 16'h000B, 16'h000C}
  };

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulseTx(input logic [15:0] d);
    @(negedge clk);
    txData  = d;
    txWrite = 1'b1;
    @(negedge clk);
    txWrite = 1'b0;
  endtask

  task automatic pulseRead();
    @(negedge clk); rxRead = 1'b1;
    @(negedge clk); rxRead = 1'b0;
  endtask

  task automatic pulseClr();
    @(negedge clk); errClr = 1'b1;
    @(negedge clk); errClr = 1'b0;
  endtask

  // Shift bits [first, first+count) of a len-bit character, MSB first.
  task automatic runBits(input int first, input int count, input int len,
                         input logic [15:0] mosiW, inout logic [15:0] misoW);
    for (int k = first; k < first + count; k++) begin
      mosiIn = mosiW[len-1-k];
      waitClk(HALF);
      misoW[len-1-k] = misoOut;
      sclkIn = 1'b1;
      waitClk(HALF);
      sclkIn = 1'b0;
    end
  endtask

  function automatic void summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] mw;
    waitClk(4);
    rstN = 1'b1;
    waitClk(2);
    // Reset state
    chk("R4 reset ready", {31'd0, rdyOe} << 1 | {31'd0, rdyOut}, 32'h3);
    chk("R7 reset miso", {31'd0, misoOe}, 32'h0);
    chk("R2 reset full", {31'd0, rxFull}, 32'h0);
    chk("R9 reset err", {31'd0, errFlag}, 32'h0);

    // Table-driven characters (push-pull ready)
    foreach (VEC[i]) begin
      cfgLen = VEC[i].len;
      pulseTx(VEC[i].tx);
      waitClk(2);
      chk("R3 ready low", {30'd0, rdyOe, rdyOut}, 32'h2);
      csN = 1'b0;
      waitClk(HALF);
      chk("R7 oe active", {31'd0, misoOe}, 32'h1);
      mw = '0;
      runBits(0, int'(VEC[i].nb), int'(VEC[i].nb), VEC[i].mosi, mw);
      waitClk(HALF);
      chk("R2 rx data", {16'd0, rxData}, {16'd0, VEC[i].rx});
      chk("R2 rx full", {31'd0, rxFull}, 32'h1);
      chk("R1 miso word", {16'd0, mw}, {16'd0, VEC[i].miso});
      chk("R4 ready high", {30'd0, rdyOe, rdyOut}, 32'h3);
      csN = 1'b1;
      pulseRead();
      waitClk(HALF);
      chk("R2 full cleared", {31'd0, rxFull}, 32'h0);
      chk("R7 oe idle", {31'd0, misoOe}, 32'h0);
    end

    // R9: clock edges while deselected after a completed character
    sclkIn = 1'b1; waitClk(HALF); sclkIn = 1'b0; waitClk(HALF);
    chk("R9 no err clean", {31'd0, errFlag}, 32'h0);

    // R5: high-impedance ready option
    cfgLen = 5'd8;
    cfgHighZ = 1'b1;
    waitClk(2);
    chk("R5 idle released", {31'd0, rdyOe}, 32'h0);
    pulseTx(16'h0055);
    waitClk(2);
    chk("R5 ready low", {30'd0, rdyOe, rdyOut}, 32'h2);
    csN = 1'b0;
    mw = '0;
    // R3: write in the middle of a character is ignored
    runBits(0, 3, 8, 16'h0081, mw);
    pulseTx(16'h00FF);
    runBits(3, 5, 8, 16'h0081, mw);
    waitClk(HALF);
    chk("R3 mid write ignored", {16'd0, mw}, 32'h55);
    chk("R2 rx 81", {16'd0, rxData}, 32'h81);
    chk("R5 done released", {31'd0, rdyOe}, 32'h0);
    csN = 1'b1;
    pulseRead();

    // R8/R9: early release with high-impedance option, then a clock edge
    pulseTx(16'h00C3);
    csN = 1'b0;
    mw = '0;
    runBits(0, 3, 8, 16'h00F0, mw);
    csN = 1'b1;
    waitClk(HALF);
    chk("R8 miso floated", {31'd0, misoOe}, 32'h0);
    chk("R8 ready released", {31'd0, rdyOe}, 32'h0);
    chk("R8 no err yet", {31'd0, errFlag}, 32'h0);
    sclkIn = 1'b1; waitClk(HALF);
    chk("R9 err set", {31'd0, errFlag}, 32'h1);
    chk("R9 irq set", {31'd0, irqOut}, 32'h1);
    sclkIn = 1'b0; waitClk(HALF * 2);
    chk("R9 err sticky", {31'd0, errFlag}, 32'h1);
    irqEn = 1'b0;
    waitClk(1);
    chk("R9 irq masked", {31'd0, irqOut}, 32'h0);
    pulseClr();
    waitClk(1);
    chk("R9 err cleared", {31'd0, errFlag}, 32'h0);
    irqEn = 1'b1;

    // R8/R10: early release in push-pull mode, then a fresh character
    cfgHighZ = 1'b0;
    csN = 1'b0;
    waitClk(HALF);
    csN = 1'b1;
    waitClk(HALF);
    pulseTx(16'h0099);
    csN = 1'b0;
    mw = '0;
    runBits(0, 2, 8, 16'h00FF, mw);
    csN = 1'b1;
    waitClk(HALF);
    chk("R8 pushpull high", {30'd0, rdyOe, rdyOut}, 32'h3);
    csN = 1'b0;
    waitClk(HALF);
    pulseTx(16'h005A);
    waitClk(2);
    chk("R10 ready again", {30'd0, rdyOe, rdyOut}, 32'h2);
    mw = '0;
    runBits(0, 8, 8, 16'h0096, mw);
    waitClk(HALF);
    chk("R10 rx after restart", {16'd0, rxData}, 32'h96);
    chk("R10 miso after restart", {16'd0, mw}, 32'h5A);
    chk("R10 no err", {31'd0, errFlag}, 32'h0);
    csN = 1'b1;
    pulseRead();

    // R6: ready function disabled
    cfgRdyEn = 1'b0;
    pulseTx(16'h0033);
    waitClk(2);
    chk("R6 ready off", {31'd0, rdyOe}, 32'h0);
    csN = 1'b0;
    mw = '0;
    runBits(0, 8, 8, 16'h00E7, mw);
    waitClk(HALF);
    chk("R6 rx works", {16'd0, rxData}, 32'hE7);
    chk("R6 miso works", {16'd0, mw}, 32'h33);
    chk("R6 still off", {31'd0, rdyOe}, 32'h0);
    csN = 1'b1;
    waitClk(HALF);

    summary();
    $finish;
  end

endmodule